// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block sits between a DMA master and the memory system and turns 32-bit device virtual addresses into physical addresses. The physical side is as wide as the frame-number width plus the 12-bit page offset. The master presents one address at a time on a valid/ready request port. The block first checks a small fully associative translation cache. If the page is cached, the physical address comes back in the cycle that follows acceptance. If it is not, the block walks a two-level table in memory, fills one cache slot and then returns the result.

Table entries carry no valid or permission bit. Every entry is used as a page frame number, even when that number is zero. Unmapped regions are expected to point at a dummy table or dummy page, so a walk never faults. The table base frame number is a static control input, and a one-cycle flush pulse empties the whole cache.

The controller is an FSM with these states: IDLE, LOOKUP, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT and DONE. Its transitions are as follows.
- IDLE moves to LOOKUP when a request is accepted.
- LOOKUP moves to IDLE on a hit, answering in that cycle, and to L1_REQ on a miss.
- L1_REQ moves to L1_WAIT after a one-cycle read strobe.
- L1_WAIT moves to L2_REQ when read data returns.
- L2_REQ moves to L2_WAIT.
- L2_WAIT moves to DONE when read data returns.
- DONE answers, fills the cache unless a flush was seen during the walk, and returns to IDLE.

Top module: `iova_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_done is 0, mem_rd_en is 0 and the cache holds no entry.
- R2: Virtual address bits [11:0] appear unchanged as rsp_paddr[11:0].
- R3: The first read of a walk goes to {root_pfn, vaddr[31:22], 2'b00}, which is the base frame shifted left by 12 plus the first-level index times 4.
- R4: The second read goes to {E1[PFN_W-1:0], vaddr[21:12], 2'b00}, where E1 is the data returned by the first read.
- R5: The result is {E2[PFN_W-1:0], vaddr[11:0]}, where E2 is the data returned by the second read. No bit of an entry is treated as a valid flag, so an entry of zero is used as frame 0.
- R6: On a cache hit, rsp_done is 1 in the cycle right after the accepting clock edge, and no memory read is issued.
- R7: On a miss, exactly two one-cycle read strobes are issued, in sequence. rsp_done is a one-cycle pulse in the cycle after the second read data returns. With a two-cycle memory this is 8 cycles after acceptance.
- R8: Fills use round-robin slot order. After TLB_DEPTH+1 distinct missed pages, the first page misses again, and the later pages still hit.
- R9: A tlb_flush pulse removes every cached entry, so the next request to any previously cached page misses.
- R10: If tlb_flush is seen during a walk, that walk still returns the correct address but is not cached. A repeat request to that page walks again.
- R11: req_ready is 0 from the cycle after acceptance through the cycle in which rsp_done is 1.
- R12: The full 32-bit range translates, including vaddr 0xFFFFFFFF, whose two table indices are 1023 and 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_done | output | 1 | One-cycle pulse, result valid |
| rsp_paddr | output | PFN_W+12 | Translated physical address |
| mem_rd_en | output | 1 | One-cycle table read strobe |
| mem_rd_addr | output | PFN_W+12 | Byte address of the table entry |
| mem_rd_valid | input | 1 | Read data returned this cycle |
| mem_rd_data | input | ENTRY_W | Table entry; low PFN_W bits are the frame number |
| root_pfn | input | PFN_W | Frame number of the first-level table |
| tlb_flush | input | 1 | Pulse: drop every cached translation |

## Verification
The bench builds the block with TLB_DEPTH = 4, PFN_W = 27 and ENTRY_W = 32. With only four slots, five distinct pages are enough to wrap the round-robin pointer, so both the eviction of the oldest page and the survival of later ones can be observed. The bench memory computes each entry from its address with a hash, and returns zero for one chosen first-level slot. This places the zero-frame case, the top of the address range and the two read addresses of each walk under exact checks.

// File: rtl/iova_xlat_pkg.sv
package iova_xlat_pkg;
    localparam int VA_W       = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int LVL_IDX_W  = 10;
    localparam int VPN_W      = VA_W - PAGE_SHIFT;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;
endpackage

// File: rtl/iova_addr_gen.sv
module iova_addr_gen
    import iova_xlat_pkg::*;
#(
    parameter int PFN_W = 27,
    localparam int PA_W = PFN_W + PAGE_SHIFT
) (
    input  logic [PFN_W-1:0] root_pfn,
    input  logic [PFN_W-1:0] l1_pfn,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l2_addr
);
    // Frame number shifted by 12 plus index times 4: the low 12 bits of the
    // base are zero, so the sum is a plain concatenation without carry.
    assign l1_addr = {root_pfn, vaddr[VA_W-1 -: LVL_IDX_W], 2'b00};
    assign l2_addr = {l1_pfn, vaddr[PAGE_SHIFT+LVL_IDX_W-1 -: LVL_IDX_W], 2'b00};
endmodule

// File: rtl/iova_tlb.sv
module iova_tlb
    import iova_xlat_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PFN_W = 27,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    logic [DEPTH-1:0] valid_q;
    logic [VPN_W-1:0] vpn_q [DEPTH];
    logic [PFN_W-1:0] pfn_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (vpn_q[g] == lk_vpn);
    end

    assign lk_hit = |hit_vec;

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_en) begin
            valid_q[ptr_q] <= 1'b1;
            ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !flush) begin
            vpn_q[ptr_q] <= fill_vpn;
            pfn_q[ptr_q] <= fill_pfn;
        end
    end

    // R8: a page is never cached in two slots at once
    p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: a flush leaves no slot occupied
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

// File: rtl/iova_walker.sv
module iova_walker
    import iova_xlat_pkg::*;
#(
    parameter int PFN_W   = 27,
    parameter int ENTRY_W = 32,
    localparam int PA_W   = PFN_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_done,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [ENTRY_W-1:0] mem_rd_data,
    input  logic               tlb_flush,
    output logic [VA_W-1:0]    vaddr,
    output logic [PFN_W-1:0]   l1_pfn,
    input  logic [PA_W-1:0]    l1_addr,
    input  logic [PA_W-1:0]    l2_addr,
    input  logic               tlb_hit,
    input  logic [PFN_W-1:0]   tlb_pfn,
    output logic               tlb_fill
);
    walk_state_e     state_q, state_d;
    logic [VA_W-1:0]  vaddr_q;
    logic [PFN_W-1:0] l1_pfn_q;
    logic [PFN_W-1:0] l2_pfn_q;
    logic             stale_q;
    logic [1:0]       rd_cnt_q;
    logic             accept;

    if (ENTRY_W > PFN_W) begin : g_hi_bits
        logic unused_hi;
        assign unused_hi = ^mem_rd_data[ENTRY_W-1:PFN_W];
    end

    assign accept = req_valid && req_ready;
    assign vaddr  = vaddr_q;
    assign l1_pfn = l1_pfn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = tlb_hit ? ST_IDLE : ST_L1_REQ;
            ST_L1_REQ:  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rd_valid) state_d = ST_L2_REQ;
            ST_L2_REQ:  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rd_valid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q  <= '0;
            l1_pfn_q <= '0;
            l2_pfn_q <= '0;
            stale_q  <= 1'b0;
            rd_cnt_q <= '0;
        end else begin
            if (accept) begin
                vaddr_q  <= req_vaddr;
                stale_q  <= 1'b0;
                rd_cnt_q <= '0;
            end else begin
                if (tlb_flush && state_q != ST_IDLE) stale_q <= 1'b1;
                if (mem_rd_en) rd_cnt_q <= rd_cnt_q + 2'd1;
            end
            if (state_q == ST_L1_WAIT && mem_rd_valid) l1_pfn_q <= mem_rd_data[PFN_W-1:0];
            if (state_q == ST_L2_WAIT && mem_rd_valid) l2_pfn_q <= mem_rd_data[PFN_W-1:0];
        end
    end

    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        mem_rd_en   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        mem_rd_addr = (state_q == ST_L1_REQ) ? l1_addr : l2_addr;
        rsp_done    = (state_q == ST_DONE) || (state_q == ST_LOOKUP && tlb_hit);
        rsp_paddr   = (state_q == ST_DONE) ? {l2_pfn_q, vaddr_q[PAGE_SHIFT-1:0]}
                                           : {tlb_pfn, vaddr_q[PAGE_SHIFT-1:0]};
        tlb_fill    = (state_q == ST_DONE) && !stale_q && !tlb_flush;
    end

    // R11: an accepted request holds the port closed in the next cycle
    p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R7: the result is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R7: a walk answers only after exactly two reads
    p_two_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (rd_cnt_q == 2'd2));

    // R6: a hit is answered without any memory traffic
    p_hit_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && tlb_hit) |-> (rd_cnt_q == 2'd0));

    // R10: a flush during a walk marks its result as not cacheable
    p_flush_marks_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_flush && !accept && state_q != ST_IDLE) |=> stale_q);
endmodule

// File: rtl/iova_xlat.sv
module iova_xlat
    import iova_xlat_pkg::*;
#(
    parameter int TLB_DEPTH = 8,
    parameter int PFN_W     = 27,
    parameter int ENTRY_W   = 32,
    localparam int PA_W     = PFN_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               rsp_done,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_rd_en,
    output logic [PA_W-1:0]    mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [ENTRY_W-1:0] mem_rd_data,
    input  logic [PFN_W-1:0]   root_pfn,
    input  logic               tlb_flush
);
    logic [VA_W-1:0]  vaddr;
    logic [PFN_W-1:0] l1_pfn;
    logic [PA_W-1:0]  l1_addr;
    logic [PA_W-1:0]  l2_addr;
    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             tlb_fill;

    iova_addr_gen #(.PFN_W(PFN_W)) u_addr (
        .root_pfn (root_pfn),
        .l1_pfn   (l1_pfn),
        .vaddr    (vaddr),
        .l1_addr  (l1_addr),
        .l2_addr  (l2_addr)
    );

    iova_tlb #(.DEPTH(TLB_DEPTH), .PFN_W(PFN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (vaddr[VA_W-1:PAGE_SHIFT]),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .flush    (tlb_flush),
        .fill_en  (tlb_fill),
        .fill_vpn (vaddr[VA_W-1:PAGE_SHIFT]),
        .fill_pfn (rsp_paddr[PA_W-1:PAGE_SHIFT])
    );

    iova_walker #(.PFN_W(PFN_W), .ENTRY_W(ENTRY_W)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_vaddr    (req_vaddr),
        .rsp_done     (rsp_done),
        .rsp_paddr    (rsp_paddr),
        .mem_rd_en    (mem_rd_en),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .tlb_flush    (tlb_flush),
        .vaddr        (vaddr),
        .l1_pfn       (l1_pfn),
        .l1_addr      (l1_addr),
        .l2_addr      (l2_addr),
        .tlb_hit      (tlb_hit),
        .tlb_pfn      (tlb_pfn),
        .tlb_fill     (tlb_fill)
    );
endmodule

// File: tb/iova_xlat_tb_top.sv
module iova_xlat_tb_top;
    localparam int DEPTH   = 4;
    localparam int PFN_W   = 27;
    localparam int ENTRY_W = 32;
    localparam int PA_W    = PFN_W + 12;
    localparam logic [PFN_W-1:0] ROOT = 27'h0012345;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic req_ready, rsp_done, mem_rd_en;
    logic [PA_W-1:0] rsp_paddr, mem_rd_addr;
    logic mem_rd_valid;
    logic [ENTRY_W-1:0] mem_rd_data;
    logic tlb_flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    iova_xlat #(.TLB_DEPTH(DEPTH), .PFN_W(PFN_W), .ENTRY_W(ENTRY_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .root_pfn(ROOT), .tlb_flush(tlb_flush)
    );

    function automatic logic [31:0] mem_word(input logic [PA_W-1:0] a);
        logic [63:0] h;
        if (a == {ROOT, 10'd5, 2'b00}) return 32'h0;
        h = 64'(a) * 64'h9E3779B1;
        return h[47:16];
    endfunction

    // Memory: data returns two cycles after a read strobe
    logic v1;
    logic [PA_W-1:0] a1;
    int rd_cnt;
    logic [PA_W-1:0] la_prev, la_last;
    always @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; a1 <= '0; mem_rd_valid <= 1'b0; mem_rd_data <= '0;
            rd_cnt <= 0; la_prev <= '0; la_last <= '0;
        end else begin
            v1 <= mem_rd_en;
            a1 <= mem_rd_addr;
            mem_rd_valid <= v1;
            mem_rd_data <= mem_word(a1);
            if (mem_rd_en) begin
                rd_cnt  <= rd_cnt + 1;
                la_prev <= la_last;
                la_last <= mem_rd_addr;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic xlat(input logic [31:0] va, input int flush_at,
                        output logic [PA_W-1:0] pa, output int cyc,
                        output int rds, output int rdy_hi);
        int base;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(posedge clk);
        cyc = 0; rdy_hi = 0; base = 0; pa = '0;
        forever begin
            @(negedge clk);
            req_valid = 1'b0;
            cyc++;
            if (cyc == 1) base = rd_cnt;
            tlb_flush = (cyc == flush_at);
            if (req_ready) rdy_hi++;
            if (rsp_done) begin
                pa = rsp_paddr;
                break;
            end
            if (cyc > 40) break;
        end
        rds = rd_cnt - base;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    // Full check of one translation against the model
    task automatic run_one(input logic [31:0] va, input bit exp_hit, input int flush_at, input string tag);
        logic [PA_W-1:0] pa, l1a, l2a, exp_pa;
        logic [31:0] e1, e2;
        int cyc, rds, rdy;
        l1a = {ROOT, va[31:22], 2'b00};
        e1  = mem_word(l1a);
        l2a = {e1[PFN_W-1:0], va[21:12], 2'b00};
        e2  = mem_word(l2a);
        exp_pa = {e2[PFN_W-1:0], va[11:0]};
        xlat(va, flush_at, pa, cyc, rds, rdy);
        chk(pa == exp_pa, {tag, " R5 R2 paddr"}, 64'(pa), 64'(exp_pa));
        chk(rdy == 0, {tag, " R11 ready while busy"}, 64'(rdy), 0);
        if (exp_hit) begin
            chk(cyc == 1, {tag, " R6 hit latency"}, 64'(cyc), 1);
            chk(rds == 0, {tag, " R6 hit reads"}, 64'(rds), 0);
        end else begin
            chk(cyc == 8, {tag, " R7 miss latency"}, 64'(cyc), 8);
            chk(rds == 2, {tag, " R7 miss reads"}, 64'(rds), 2);
            chk(la_prev == l1a, {tag, " R3 first read addr"}, 64'(la_prev), 64'(l1a));
            chk(la_last == l2a, {tag, " R4 second read addr"}, 64'(la_last), 64'(l2a));
        end
    endtask

    // {vaddr, expected hit}
    localparam logic [32:0] VEC [12] = '{
        {32'h0000_0123, 1'b0},   // page A
        {32'h0000_0FFF, 1'b1},   // A again, offset top
        {32'h0040_0456, 1'b0},   // page B
        {32'h0000_1789, 1'b0},   // page C
        {32'hFFFF_FFFF, 1'b0},   // page D, R12
        {32'h0040_0000, 1'b1},   // B hit
        {32'h0140_0ABC, 1'b0},   // page E, zero first-level entry, R5
        {32'h0000_0000, 1'b0},   // A evicted by round robin, R8
        {32'h0000_1000, 1'b1},   // C still cached, R8
        {32'hFFFF_F000, 1'b1},   // D still cached, R12
        {32'h0040_0111, 1'b0},   // B evicted next, R8
        {32'h0000_1ABC, 1'b0}    // C evicted after that, R8
    };

    initial begin
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 64'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        chk(rsp_done == 1'b0, "R1 done after reset", 64'(rsp_done), 0);
        chk(mem_rd_en == 1'b0, "R1 no read after reset", 64'(mem_rd_en), 0);

        for (int i = 0; i < 12; i++) begin
            run_one(VEC[i][32:1], VEC[i][0], 0, $sformatf("vec%0d", i));
        end

        // R1: the cache is empty after a fresh reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_one(32'hFFFF_F000, 1'b0, 0, "R1 empty after reset");

        // R9: a flush drops all cached pages
        run_one(32'h0000_1234, 1'b0, 0, "R9 prime");
        run_one(32'h0000_1000, 1'b1, 0, "R9 cached");
        @(negedge clk); tlb_flush = 1'b1;
        @(negedge clk); tlb_flush = 1'b0;
        run_one(32'h0000_1555, 1'b0, 0, "R9 after flush");
        run_one(32'hFFFF_F010, 1'b0, 0, "R9 other page after flush");

        // R10: flush during a walk, result correct but not cached
        run_one(32'h0080_2345, 1'b0, 3, "R10 flushed walk");
        run_one(32'h0080_2000, 1'b0, 0, "R10 rewalk");
        run_one(32'h0080_2FFF, 1'b1, 0, "R10 cached after clean walk");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule